// File: doc/BRIEF.md
# Banked Register-Window Data Address Decoder

This block sits between a small CPU core and its data memories. The core's eight working registers are aliased into the top of a 256-byte internal RAM. The decoder takes one data request at a time, either a full 16-bit address or a short 8-bit one. It sends the request to one of four places: a special-function-register (SFR) port, the internal RAM, the live working registers, or an external bus. The external bus uses a valid/ready handshake. A mode input can widen external addresses to 20 bits. A 4-bit segment value is placed above the 16-bit address. One segment input serves normal accesses and a second serves accesses flagged as alternate.

The block also owns the working registers and runs register-bank changes. There are four banks, and each one owns an 8-byte window of internal RAM. The selected bank's window is not stored in RAM: any access that falls inside it reaches the live register instead. A bank change to a different bank first writes the eight live registers out to the old bank's window. It then loads them from the new bank's window, one byte per cycle, and holds `busy` high while it does so.

The controller has four states:
- **IDLE**: serves internal accesses in the same cycle, and accepts bank changes and external requests.
- **EXT**: waits for the external bus.
- **SPILL**: writes the registers out to RAM.
- **FILL**: loads the registers from RAM.

It has five transitions:
- **IDLE→SPILL**: a bank change is requested to a bank other than the current one. This takes priority over a request arriving in the same cycle.
- **IDLE→EXT**: a request decodes to the external bus.
- **EXT→IDLE**: `ext_ready` is high.
- **SPILL→FILL**: after the eighth byte has been written out.
- **FILL→IDLE**: after the eighth byte has been loaded. The bank select takes the new value on this transition.

Top module: `bankwin_decoder`

## Requirements
- R1: With the segment bits zero, a long address from 0xFF00 to 0xFFFF is served in the same cycle through the SFR port (`sfr_en` high), using address bits 7:0 as the SFR offset; reads return `sfr_rdata` and writes present `req_wdata` with `sfr_we` high.
- R2: With the segment bits zero, a long address from 0xFE00 to 0xFEFF addresses internal RAM cell (address bits 7:0), unless R4 redirects it; reads return the stored byte in the same cycle.
- R3: A long address below 0xFE00, or any long address with nonzero segment bits, goes to the external bus. From the next cycle `ext_valid` is high with `ext_addr` = {segment, address}, and `req_ready` follows `ext_ready`, so the requester stalls until the bus answers; reads return `ext_rdata`.
- R4: Bank n (0 to 3) owns RAM offsets 0xF8−8n to 0xFF−8n. An internal RAM access inside the selected bank's window reads or writes working register (offset AND 7) instead. Register index order is X, A, C, B, E, D, L, H for 0 to 7, and register i is `regs_q[8i+7:8i]`.
- R5: In short mode only address bits 7:0 are used. A value of 0xE0 or above selects SFR offset (value − 0xE0). A lower value selects internal RAM offset (value + 0x20), and R4 still applies.
- R6: When `ext_mode` is high, the segment is `seg_alt` for requests with `req_alt` high and `seg_norm` otherwise. When `ext_mode` is low, the segment is zero and `req_alt` has no effect.
- R7: A bank change to a different bank writes registers 0 to 7 to RAM offsets base(old)+0 to base(old)+7, where base(n) = 0xF8 − 8n. It then loads them from base(new)+0 to base(new)+7 and sets `cur_bank` to the new bank.
- R8: A bank change keeps `busy` high for exactly 16 cycles, one per byte moved. While `busy` is high no request is served: `req_ready`, `sfr_en` and `ext_valid` stay low. A bank change wins over a request presented in the same cycle.
- R9: A bank change to the bank already selected does nothing: `busy` stays low, and `cur_bank` and the registers keep their values.
- R10: After reset, `cur_bank` is 0, every working register is 0, and `busy`, `sfr_en` and `ext_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Data request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | Short 8-bit address form |
| req_alt | input | 1 | Use the alternate segment |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | 8 | Read data, valid with `req_ready` |
| ext_mode | input | 1 | Address extension enable (mode register bit 6) |
| seg_norm | input | 4 | Segment for normal accesses |
| seg_alt | input | 4 | Segment for alternate accesses |
| sw_start | input | 1 | Bank change request |
| sw_bank | input | 2 | Target bank |
| busy | output | 1 | Bank change in progress |
| cur_bank | output | 2 | Selected bank |
| core_we | input | 1 | Direct working-register write from the core |
| core_idx | input | 3 | Register index for `core_we` |
| core_wdata | input | 8 | Data for `core_we` |
| regs_q | output | 64 | All eight working registers |
| sfr_en | output | 1 | SFR access strobe |
| sfr_we | output | 1 | SFR write |
| sfr_off | output | 8 | SFR offset |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data (combinational) |
| ext_valid | output | 1 | External bus request |
| ext_we | output | 1 | External write |
| ext_addr | output | 20 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |
| ext_ready | input | 1 | External bus completes |

## Verification
The bench exercises the edges of each address range: 0xFDFF against 0xFE00, 0xFF00, and the short form on both sides of 0xDF/0xE0. An off-by-one in the range compares would send these accesses to the wrong port and return bench-generated SFR or external data in place of RAM contents. It reads both inside and just outside the bank window. It reads the old window again after a bank change, which shows whether the spill landed at the right base and in X-to-H order. A swapped index or a wrong base would return foreign bytes. It also covers a bank change to the bank already selected, which a careless design would run as a spill and fill, and a request held during the change, which must not complete early. Segment selection is checked with the alternate flag set while extension is both on and off, so a design that ignores the mode bit shows up as a wrong external address.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        TGT_SFR,
        TGT_RAM,
        TGT_REG,
        TGT_EXT
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_SPILL,
        ST_FILL
    } st_e;

    // First RAM offset of a bank's register window
    function automatic logic [7:0] win_base(input logic [1:0] bank);
        return 8'hF8 - {3'b000, bank, 3'b000};
    endfunction

endpackage

// File: rtl/bwd_addr_map.sv
module bwd_addr_map
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    short_mode,
    input  logic                    alt_sel,
    input  logic                    ext_mode,
    input  logic [SEG_W-1:0]        seg_norm,
    input  logic [SEG_W-1:0]        seg_alt,
    input  logic [1:0]              bank,
    output tgt_e                    tgt,
    output logic [7:0]              off,
    output logic [ADDR_W+SEG_W-1:0] full_addr
);
    localparam logic [ADDR_W-1:0] SFR_LO = ADDR_W'('hFF00);
    localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'('hFE00);

    logic [SEG_W-1:0] seg;
    tgt_e             tgt_raw;
    logic             in_win;

    always_comb begin
        seg       = ext_mode ? (alt_sel ? seg_alt : seg_norm) : '0;
        full_addr = {seg, addr};
        off       = addr[7:0];
        tgt_raw   = TGT_EXT;
        if (short_mode) begin
            if (addr[7:0] >= 8'hE0) begin
                tgt_raw = TGT_SFR;
                off     = addr[7:0] - 8'hE0;
            end else begin
                tgt_raw = TGT_RAM;
                off     = addr[7:0] + 8'h20;
            end
        end else if (seg != '0) begin
            tgt_raw = TGT_EXT;
        end else if (addr >= SFR_LO) begin
            tgt_raw = TGT_SFR;
        end else if (addr >= RAM_LO) begin
            tgt_raw = TGT_RAM;
        end
        in_win = (off[7:5] == 3'b111) && (off[4:3] == ~bank);
        tgt    = (tgt_raw == TGT_RAM && in_win) ? TGT_REG : tgt_raw;
    end

endmodule

// File: rtl/bwd_iram.sv
module bwd_iram #(
    parameter int DATA_W = 8,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bwd_regfile.sv
module bwd_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  widx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(NREG)-1:0]  ridx,
    output logic [DATA_W-1:0]        rdata,
    output logic [NREG*DATA_W-1:0]   flat
);
    logic [DATA_W-1:0] r [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r[i] <= '0;
            end else if (we && widx == i) begin
                r[i] <= wdata;
            end
        end
        assign flat[i*DATA_W +: DATA_W] = r[i];
    end

    assign rdata = r[ridx];

endmodule

// File: rtl/bankwin_decoder.sv
module bankwin_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_short,
    input  logic                    req_alt,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ready,
    output logic [DATA_W-1:0]       req_rdata,
    input  logic                    ext_mode,
    input  logic [SEG_W-1:0]        seg_norm,
    input  logic [SEG_W-1:0]        seg_alt,
    input  logic                    sw_start,
    input  logic [1:0]              sw_bank,
    output logic                    busy,
    output logic [1:0]              cur_bank,
    input  logic                    core_we,
    input  logic [2:0]              core_idx,
    input  logic [DATA_W-1:0]       core_wdata,
    output logic [8*DATA_W-1:0]     regs_q,
    output logic                    sfr_en,
    output logic                    sfr_we,
    output logic [7:0]              sfr_off,
    output logic [DATA_W-1:0]       sfr_wdata,
    input  logic [DATA_W-1:0]       sfr_rdata,
    output logic                    ext_valid,
    output logic                    ext_we,
    output logic [ADDR_W+SEG_W-1:0] ext_addr,
    output logic [DATA_W-1:0]       ext_wdata,
    input  logic [DATA_W-1:0]       ext_rdata,
    input  logic                    ext_ready
);
    localparam int NREG  = 8;
    localparam int IDX_W = $clog2(NREG);
    localparam int RAM_AW = 8;

    st_e               st, st_nx;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        new_bank;
    tgt_e              tgt;
    logic [7:0]        off;
    logic              start_sw;
    logic              acc;

    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_wdata, ram_q;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_widx, rf_ridx;
    logic [DATA_W-1:0] rf_wdata, rf_q;

    bwd_addr_map #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_map (
        .addr      (req_addr),
        .short_mode(req_short),
        .alt_sel   (req_alt),
        .ext_mode  (ext_mode),
        .seg_norm  (seg_norm),
        .seg_alt   (seg_alt),
        .bank      (cur_bank),
        .tgt       (tgt),
        .off       (off),
        .full_addr (ext_addr)
    );

    bwd_iram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(ram_raddr),
        .rdata(ram_q)
    );

    bwd_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (rf_we),
        .widx (rf_widx),
        .wdata(rf_wdata),
        .ridx (rf_ridx),
        .rdata(rf_q),
        .flat (regs_q)
    );

    assign start_sw = (st == ST_IDLE) && sw_start && (sw_bank != cur_bank);
    assign acc      = (st == ST_IDLE) && req_valid && !start_sw;
    assign busy     = (st == ST_SPILL) || (st == ST_FILL);

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start_sw) begin
                    st_nx = ST_SPILL;
                end else if (acc && tgt == TGT_EXT) begin
                    st_nx = ST_EXT;
                end
            end
            ST_EXT: begin
                if (ext_ready) begin
                    st_nx = ST_IDLE;
                end
            end
            ST_SPILL: begin
                if (idx == IDX_W'(NREG - 1)) begin
                    st_nx = ST_FILL;
                end
            end
            ST_FILL: begin
                if (idx == IDX_W'(NREG - 1)) begin
                    st_nx = ST_IDLE;
                end
            end
        endcase
    end

    // State register, byte counter and bank select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            idx      <= '0;
            new_bank <= '0;
            cur_bank <= '0;
        end else begin
            st <= st_nx;
            if (start_sw) begin
                new_bank <= sw_bank;
                idx      <= '0;
            end else if (busy) begin
                idx <= idx + 1'b1;
            end
            if (st == ST_FILL && st_nx == ST_IDLE) begin
                cur_bank <= new_bank;
            end
        end
    end

    // Outputs and datapath steering
    always_comb begin
        req_ready = 1'b0;
        req_rdata = '0;
        sfr_en    = 1'b0;
        sfr_we    = 1'b0;
        sfr_off   = off;
        sfr_wdata = req_wdata;
        ext_valid = 1'b0;
        ext_we    = req_write;
        ext_wdata = req_wdata;
        ram_we    = 1'b0;
        ram_waddr = off;
        ram_wdata = req_wdata;
        ram_raddr = off;
        rf_we     = 1'b0;
        rf_widx   = off[IDX_W-1:0];
        rf_wdata  = req_wdata;
        rf_ridx   = off[IDX_W-1:0];
        unique case (st)
            ST_IDLE: begin
                if (acc) begin
                    unique case (tgt)
                        TGT_SFR: begin
                            sfr_en    = 1'b1;
                            sfr_we    = req_write;
                            req_ready = 1'b1;
                            req_rdata = sfr_rdata;
                        end
                        TGT_RAM: begin
                            ram_we    = req_write;
                            req_ready = 1'b1;
                            req_rdata = ram_q;
                        end
                        TGT_REG: begin
                            rf_we     = req_write;
                            req_ready = 1'b1;
                            req_rdata = rf_q;
                        end
                        TGT_EXT: begin
                            req_ready = 1'b0;
                        end
                    endcase
                end
                if (!rf_we && core_we) begin
                    rf_we    = 1'b1;
                    rf_widx  = core_idx;
                    rf_wdata = core_wdata;
                end
            end
            ST_EXT: begin
                ext_valid = 1'b1;
                req_ready = ext_ready;
                req_rdata = ext_rdata;
            end
            ST_SPILL: begin
                rf_ridx   = idx;
                ram_we    = 1'b1;
                ram_waddr = win_base(cur_bank) + {5'b0, idx};
                ram_wdata = rf_q;
            end
            ST_FILL: begin
                ram_raddr = win_base(new_bank) + {5'b0, idx};
                rf_we     = 1'b1;
                rf_widx   = idx;
                rf_wdata  = ram_q;
            end
        endcase
    end

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [1:0] cur_bank,
    input logic       req_valid,
    input logic       req_ready,
    input logic       sfr_en,
    input logic       ext_valid,
    input logic       sw_start,
    input logic [1:0] sw_bank
);
    localparam int NREG    = 8;
    localparam int SW_LEN  = 2 * NREG;
    localparam int CNT_W   = $clog2(SW_LEN) + 1;

    logic [CNT_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (busy) begin
            run <= run + 1'b1;
        end else begin
            run <= '0;
        end
    end

    // R8: nothing is served while the bank change runs
    a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!req_ready && !sfr_en && !ext_valid));

    // R8: a busy run never exceeds its length and ends exactly at it
    a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < CNT_W'(SW_LEN)));

    a_r8_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == CNT_W'(SW_LEN)));

    // R7: a completed change lands on a different bank
    a_r7_bank_moved: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cur_bank != $past(cur_bank)));

    // R9: a change to the selected bank starts nothing
    a_r9_same_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_start && sw_bank == cur_bank) |=> (!busy && $stable(cur_bank)));

    // R1: SFR accesses finish in the cycle they are strobed
    a_r1_sfr_single: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_en |-> req_ready);

    // R3: the external bus is only driven for a pending request
    a_r3_ext_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> req_valid);

endmodule

bind bankwin_decoder bwd_checker u_bwd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cur_bank (cur_bank),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .sfr_en   (sfr_en),
    .ext_valid(ext_valid),
    .sw_start (sw_start),
    .sw_bank  (sw_bank)
);

// File: tb/bankwin_decoder_bench.sv
module bankwin_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_short = 1'b0, req_alt = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic        ext_mode = 1'b0;
    logic [3:0]  seg_norm = 4'h3, seg_alt = 4'h9;
    logic        sw_start = 1'b0;
    logic [1:0]  sw_bank = '0;
    logic        busy;
    logic [1:0]  cur_bank;
    logic        core_we = 1'b0;
    logic [2:0]  core_idx = '0;
    logic [7:0]  core_wdata = '0;
    logic [63:0] regs_q;
    logic        sfr_en, sfr_we;
    logic [7:0]  sfr_off, sfr_wdata, sfr_rdata;
    logic        ext_valid, ext_we;
    logic [19:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;
    logic        ext_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ecnt = 0;
    logic [19:0] last_ext_addr = '0;
    logic        last_ext_we = 1'b0;
    logic [7:0]  last_ext_wdata = '0;
    logic [7:0]  last_sfr_off = '0, last_sfr_wdata = '0;

    always #10 clk = ~clk;

    bankwin_decoder u_bankwin_decoder (.*);

    // SFR model: reads return the inverted offset
    assign sfr_rdata = ~sfr_off;
    // External model: answers on the second falling edge of a request
    assign ext_rdata = ext_addr[7:0] ^ {ext_addr[19:16], 4'h5};

    always @(negedge clk) begin
        ext_ready <= 1'b0;
        if (ext_valid && !ext_ready) begin
            if (ecnt == 1) begin
                ext_ready      <= 1'b1;
                ecnt           <= 0;
                last_ext_addr  <= ext_addr;
                last_ext_we    <= ext_we;
                last_ext_wdata <= ext_wdata;
            end else begin
                ecnt <= ecnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (sfr_en && sfr_we) begin
            last_sfr_off   <= sfr_off;
            last_sfr_wdata <= sfr_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic sh, input logic alt, input logic em,
                          input logic [15:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output int waits);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_short = sh; req_alt = alt;
        ext_mode = em; req_addr = a; req_wdata = wd;
        waits = 0;
        #2;
        while (!req_ready && waits < 50) begin
            waits++;
            @(negedge clk);
            #2;
        end
        rd = req_rdata;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bank_switch(input logic [1:0] b, output int busy_n, output int early);
        @(negedge clk);
        sw_start = 1'b1; sw_bank = b;
        req_valid = 1'b1; req_write = 1'b0; req_short = 1'b0; ext_mode = 1'b0;
        req_addr = 16'hFF12;
        busy_n = 0; early = 0;
        #2 if (req_ready) early++;
        @(posedge clk);
        #1 sw_start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            #2;
            if (!busy) break;
            busy_n++;
            if (req_ready) early++;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // {short, alt, ext_mode, addr[15:0], expected read}
    localparam int NV = 16;
    localparam logic [26:0] VEC [NV] = '{
        {3'b000, 16'hFF12, 8'hED},  // R1 SFR range
        {3'b000, 16'hFF00, 8'hFF},  // R1 lower edge of SFR range
        {3'b000, 16'hFE40, 8'hA5},  // R2 internal RAM
        {3'b000, 16'hFEF8, 8'h10},  // R4 bank 0 window, X
        {3'b000, 16'hFEFF, 8'h17},  // R4 bank 0 window, H
        {3'b000, 16'hFEF0, 8'h5A},  // R4 outside selected window is RAM
        {3'b100, 16'h0020, 8'hA5},  // R5 short to RAM 0x40
        {3'b100, 16'h00E5, 8'hFA},  // R5 short to SFR 0x05
        {3'b100, 16'h00D8, 8'h10},  // R5 short into window, X
        {3'b100, 16'h00DF, 8'h17},  // R5 short edge below 0xE0, H
        {3'b000, 16'h1234, 8'h31},  // R3 external
        {3'b000, 16'hFDFF, 8'hFA},  // R3 edge just below RAM
        {3'b010, 16'h1234, 8'h31},  // R6 alt ignored with extension off
        {3'b001, 16'h1234, 8'h01},  // R6 normal segment 3
        {3'b011, 16'h1234, 8'hA1},  // R6 alternate segment 9
        {3'b001, 16'hFE40, 8'h75}   // R6 nonzero segment goes external
    };

    initial begin
        logic [7:0] rd;
        int waits, bn, early;

        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 regs", regs_q, 64'h0);
        chk("R10 busy", busy, 1'b0);
        chk("R10 bank", cur_bank, 2'd0);
        chk("R10 strobes", {sfr_en, ext_valid}, 2'b00);
        rst_n = 1'b1;

        // Preload registers X..H with 0x10..0x17 through the core port
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            core_we = 1'b1; core_idx = 3'(i); core_wdata = 8'h10 + 8'(i);
        end
        @(negedge clk) core_we = 1'b0;
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'hFE40, 8'hA5, rd, waits);
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'hFEF0, 8'h5A, rd, waits);

        for (int v = 0; v < NV; v++) begin
            access(1'b0, VEC[v][26], VEC[v][25], VEC[v][24], VEC[v][23:8], 8'h00, rd, waits);
            chk($sformatf("vector %0d read", v), rd, VEC[v][7:0]);
            if (VEC[v][26] == 1'b0 && (VEC[v][24] || VEC[v][23:8] < 16'hFE00)) begin
                chk($sformatf("R3 stall vector %0d", v), waits >= 2, 1'b1);
            end else begin
                chk($sformatf("R1 R2 single cycle vector %0d", v), waits, 0);
            end
        end

        // R1 SFR write, R5 short SFR write, R3 external write
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'hFF34, 8'h77, rd, waits);
        chk("R1 sfr write", {last_sfr_off, last_sfr_wdata}, 16'h3477);
        access(1'b1, 1'b1, 1'b0, 1'b0, 16'h00E7, 8'h88, rd, waits);
        chk("R5 short sfr write", {last_sfr_off, last_sfr_wdata}, 16'h0788);
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'h0123, 8'h5E, rd, waits);
        chk("R3 ext write", {last_ext_we, last_ext_addr, last_ext_wdata}, {1'b1, 20'h00123, 8'h5E});

        // R4 write into window hits register A, not RAM
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'hFEF9, 8'h21, rd, waits);
        chk("R4 window write", regs_q[15:8], 8'h21);

        // Fill bank 1 window 0xF0..0xF7 with 0x60..0x67
        for (int i = 0; i < 8; i++) begin
            access(1'b1, 1'b0, 1'b0, 1'b0, 16'hFEF0 + 16'(i), 8'h60 + 8'(i), rd, waits);
        end

        // R7 R8 switch to bank 1 with a request held
        bank_switch(2'd1, bn, early);
        chk("R8 busy cycles", bn, 16);
        chk("R8 no early service", early, 0);
        chk("R7 bank", cur_bank, 2'd1);
        chk("R7 loaded regs", regs_q, 64'h6766656463626160);
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'hFEF8, 8'h00, rd, waits);
        chk("R7 spilled X", rd, 8'h10);
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'hFEF9, 8'h00, rd, waits);
        chk("R7 spilled A", rd, 8'h21);
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'hFEFF, 8'h00, rd, waits);
        chk("R7 spilled H", rd, 8'h17);
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'hFEF0, 8'h00, rd, waits);
        chk("R4 bank 1 window X", rd, 8'h60);
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'hFEF3, 8'hCC, rd, waits);
        chk("R4 bank 1 write B", regs_q[31:24], 8'hCC);

        // R9 same bank does nothing
        bank_switch(2'd1, bn, early);
        chk("R9 no busy", bn, 0);
        chk("R9 bank kept", cur_bank, 2'd1);
        chk("R9 regs kept", regs_q, 64'h67666564CC626160);

        // R7 back to bank 0
        bank_switch(2'd0, bn, early);
        chk("R8 busy cycles back", bn, 16);
        chk("R7 bank back", cur_bank, 2'd0);
        chk("R7 regs back", regs_q, 64'h1716151413122110);
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'hFEF3, 8'h00, rd, waits);
        chk("R7 bank 1 spill of B", rd, 8'hCC);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule